// File: doc/BRIEF.md
# Four-State Branch Direction Predictor

This block keeps a small table of direction-prediction state, one entry per branch slot, selected by the low bits of the branch address. A fetch stage presents an index on the lookup port and receives, in the same cycle, a taken or not-taken guess together with the full two-bit state of that entry. Once the branch resolves, the execute stage sends its index and real outcome on the update port, and the entry moves to its next state at the following clock edge.

Each entry has four states: two strong and two weak, for each direction. The transitions are deliberately asymmetric. A taken outcome while weakly not-taken jumps directly to strongly taken. This means that a branch closing a loop is predicted correctly on every later entry into the loop, and is wrong only on the exit iteration. A preset port lets software-supplied hints overwrite any entry's state. Entries that never receive a hint begin in the hardware's default guess, which is weakly not-taken.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every entry holds state code 2'b01 (weakly not-taken), and lookups on any index return that code with a not-taken prediction.
- R2: The state codes are 2'b11 strongly taken, 2'b10 weakly taken, 2'b01 weakly not-taken and 2'b00 strongly not-taken. lk_taken is 1 exactly for the codes 2'b11 and 2'b10.
- R3: An update with a taken outcome on an entry in 2'b01 moves it to 2'b11 at the next edge.
- R4: Updates on an entry that predicts taken move it as follows: 2'b11 taken goes to 2'b11; 2'b11 not-taken goes to 2'b10; 2'b10 taken goes to 2'b11; 2'b10 not-taken goes to 2'b00.
- R5: Updates on an entry that predicts not-taken move it as follows: 2'b00 taken goes to 2'b01; 2'b00 not-taken goes to 2'b00; 2'b01 not-taken goes to 2'b00.
- R6: Starting from either strong state, the predicted direction is unchanged after one misprediction and reverses after a second consecutive one.
- R7: A preset writes pr_state into the selected entry at the next edge. If a preset and an update target the same index in the same cycle, the preset wins.
- R8: Updates and presets change only the entry at their own index. Every other entry keeps its state.
- R9: When a lookup and an update name the same index in the same cycle, the lookup returns the state from before the update. The new state becomes visible after the edge.
- R10: For a branch taken K times and then not taken once, replayed twice from reset, the first pass has two mispredictions and the second pass has exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | IDX_W | Low branch-address bits selecting the entry to look up |
| lk_taken | output | 1 | Predicted direction of the looked-up entry |
| lk_state | output | 2 | Full state code of the looked-up entry |
| up_valid | input | 1 | Resolved outcome present this cycle |
| up_idx | input | IDX_W | Entry index of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| pr_valid | input | 1 | Hint preset present this cycle |
| pr_idx | input | IDX_W | Entry index to preset |
| pr_state | input | 2 | State code to load |

## Verification
The functions that can meet in one cycle are a resolved update and either a lookup or a preset of the same entry. For the lookup case, the bench drives the lookup and the update on one index together. It reads the lookup output before the edge and expects the old state, then reads it again after the edge and expects the stepped state. For the preset case, a preset and a conflicting taken update go to one entry together. The bench judges the result by the entry settling at the preset value rather than at the stepped one.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    typedef enum logic [1:0] {
        PS_STRONG_NT = 2'b00,
        PS_WEAK_NT   = 2'b01,
        PS_WEAK_TK   = 2'b10,
        PS_STRONG_TK = 2'b11
    } bp_state_e;

    localparam bp_state_e PS_RESET = PS_WEAK_NT;
endpackage

// File: rtl/bdp_next.sv
module bdp_next
    import bdp_pkg::*;
(
    input  bp_state_e cur_i,
    input  logic      taken_i,
    output bp_state_e nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            PS_STRONG_TK: nxt_o = taken_i ? PS_STRONG_TK : PS_WEAK_TK;
            PS_WEAK_TK:   nxt_o = taken_i ? PS_STRONG_TK : PS_STRONG_NT;
            PS_WEAK_NT:   nxt_o = taken_i ? PS_STRONG_TK : PS_STRONG_NT;
            PS_STRONG_NT: nxt_o = taken_i ? PS_WEAK_NT   : PS_STRONG_NT;
            default:      nxt_o = PS_RESET;
        endcase
    end
endmodule

// File: rtl/bdp_entry.sv
module bdp_entry
    import bdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd_hit_i,
    input  logic      upd_taken_i,
    input  logic      pre_hit_i,
    input  bp_state_e pre_state_i,
    output bp_state_e state_o
);
    typedef struct packed {
        bp_state_e state;
    } entry_regs_t;

    entry_regs_t regs_d, regs_q;
    bp_state_e   stepped;

    bdp_next u_next (
        .cur_i   (regs_q.state),
        .taken_i (upd_taken_i),
        .nxt_o   (stepped)
    );

    always_comb begin
        regs_d = regs_q;
        if (pre_hit_i) begin
            regs_d.state = pre_state_i;
        end else if (upd_hit_i) begin
            regs_d.state = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: PS_RESET};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> regs_q.state == PS_WEAK_NT);

    assert_preset_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit_i |=> regs_q.state == $past(pre_state_i));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_hit_i && !upd_hit_i |=> $stable(regs_q.state));

    assert_weak_nt_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit_i && !pre_hit_i && upd_taken_i && regs_q.state == PS_WEAK_NT
        |=> regs_q.state == PS_STRONG_TK);

    assert_strong_tk_one_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit_i && !pre_hit_i && !upd_taken_i && regs_q.state == PS_STRONG_TK
        |=> regs_q.state[1]);

    assert_strong_nt_one_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit_i && !pre_hit_i && upd_taken_i && regs_q.state == PS_STRONG_NT
        |=> !regs_q.state[1]);

    assert_strong_nt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit_i && !pre_hit_i && !upd_taken_i && regs_q.state == PS_STRONG_NT
        |=> regs_q.state == PS_STRONG_NT);
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    output logic [1:0]       lk_state,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_taken,
    input  logic             pr_valid,
    input  logic [IDX_W-1:0] pr_idx,
    input  logic [1:0]       pr_state
);
    localparam int ENTRIES = 1 << IDX_W;

    bp_state_e ent_state [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic upd_hit, pre_hit;
        assign upd_hit = up_valid && (up_idx == MY_IDX);
        assign pre_hit = pr_valid && (pr_idx == MY_IDX);

        bdp_entry u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .upd_hit_i   (upd_hit),
            .upd_taken_i (up_taken),
            .pre_hit_i   (pre_hit),
            .pre_state_i (bp_state_e'(pr_state)),
            .state_o     (ent_state[g])
        );
    end

    bp_state_e sel_state;
    always_comb begin
        sel_state = ent_state[lk_idx];
        lk_state  = sel_state;
        lk_taken  = (sel_state == PS_STRONG_TK) || (sel_state == PS_WEAK_TK);
    end
endmodule

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb;
    localparam int IDX_W = 6;
    localparam int K = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] lk_idx = '0;
    logic             lk_taken;
    logic [1:0]       lk_state;
    logic             up_valid = 1'b0;
    logic [IDX_W-1:0] up_idx = '0;
    logic             up_taken = 1'b0;
    logic             pr_valid = 1'b0;
    logic [IDX_W-1:0] pr_idx = '0;
    logic [1:0]       pr_state = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    branch_dir_predictor #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_taken(lk_taken), .lk_state(lk_state),
        .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken),
        .pr_valid(pr_valid), .pr_idx(pr_idx), .pr_state(pr_state)
    );

    // vector: {start state, outcome, expected state, requirement number}
    localparam logic [8:0] VEC [8] = '{
        {2'b11, 1'b1, 2'b11, 4'd4},
        {2'b11, 1'b0, 2'b10, 4'd4},
        {2'b10, 1'b1, 2'b11, 4'd4},
        {2'b10, 1'b0, 2'b00, 4'd4},
        {2'b01, 1'b1, 2'b11, 4'd3},
        {2'b01, 1'b0, 2'b00, 4'd5},
        {2'b00, 1'b1, 2'b01, 4'd5},
        {2'b00, 1'b0, 2'b00, 4'd5}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input int req, input logic [1:0] act, input logic [1:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic preset(input logic [IDX_W-1:0] idx, input logic [1:0] st);
        pr_valid = 1'b1; pr_idx = idx; pr_state = st;
        tick();
        pr_valid = 1'b0;
    endtask

    task automatic update(input logic [IDX_W-1:0] idx, input logic tk);
        up_valid = 1'b1; up_idx = idx; up_taken = tk;
        tick();
        up_valid = 1'b0;
    endtask

    task automatic peek(input logic [IDX_W-1:0] idx);
        lk_idx = idx;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int miss;
        logic pred;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state on several indices
        for (int i = 0; i < 64; i += 21) begin
            peek(IDX_W'(i));
            chk(1, lk_state, 2'b01, "reset state");
            chk(1, {1'b0, lk_taken}, 2'b00, "reset prediction");
        end

        // R3 R4 R5: transition table walk
        for (int i = 0; i < 8; i++) begin
            logic [IDX_W-1:0] idx;
            idx = IDX_W'(i + 8);
            preset(idx, VEC[i][8:7]);
            update(idx, VEC[i][6]);
            peek(idx);
            chk(int'(VEC[i][3:0]), lk_state, VEC[i][5:4], "transition");
        end

        // R2: prediction bit for each code
        for (int c = 0; c < 4; c++) begin
            preset(IDX_W'(40), 2'(c));
            peek(IDX_W'(40));
            chk(2, {1'b0, lk_taken}, {1'b0, (c >= 2)}, "prediction of code");
        end

        // R6: two consecutive misses needed from strong taken
        preset(IDX_W'(41), 2'b11);
        update(IDX_W'(41), 1'b0);
        peek(IDX_W'(41));
        chk(6, {1'b0, lk_taken}, 2'b01, "strong taken after one miss");
        update(IDX_W'(41), 1'b0);
        peek(IDX_W'(41));
        chk(6, {1'b0, lk_taken}, 2'b00, "strong taken after two misses");
        // R6: from strong not-taken
        preset(IDX_W'(42), 2'b00);
        update(IDX_W'(42), 1'b1);
        peek(IDX_W'(42));
        chk(6, {1'b0, lk_taken}, 2'b00, "strong not-taken after one miss");
        update(IDX_W'(42), 1'b1);
        peek(IDX_W'(42));
        chk(6, {1'b0, lk_taken}, 2'b01, "strong not-taken after two misses");

        // R7: preset wins over update on same index
        pr_valid = 1'b1; pr_idx = IDX_W'(43); pr_state = 2'b00;
        up_valid = 1'b1; up_idx = IDX_W'(43); up_taken = 1'b1;
        tick();
        pr_valid = 1'b0; up_valid = 1'b0;
        peek(IDX_W'(43));
        chk(7, lk_state, 2'b00, "preset versus update");

        // R8: neighbours untouched
        preset(IDX_W'(45), 2'b10);
        update(IDX_W'(45), 1'b0);
        peek(IDX_W'(44));
        chk(8, lk_state, 2'b01, "lower neighbour");
        peek(IDX_W'(46));
        chk(8, lk_state, 2'b01, "upper neighbour");

        // R9: lookup and update on one index in one cycle
        lk_idx = IDX_W'(50);
        up_valid = 1'b1; up_idx = IDX_W'(50); up_taken = 1'b1;
        #1;
        chk(9, lk_state, 2'b01, "lookup before edge");
        tick();
        up_valid = 1'b0;
        chk(9, lk_state, 2'b11, "lookup after edge");

        // R10: loop branch replayed twice
        for (int p = 0; p < 2; p++) begin
            miss = 0;
            for (int j = 0; j <= K; j++) begin
                peek(IDX_W'(60));
                pred = lk_taken;
                if (pred != (j < K)) miss++;
                update(IDX_W'(60), (j < K));
            end
            chk(10, 2'(miss), (p == 0) ? 2'd2 : 2'd1, "mispredictions per pass");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule